// File: doc/BRIEF.md
# DMA Interrupt Pending Aggregator

This block gathers transfer-progress events from sixteen DMA channels, eight in a normal group and eight in a dedicated group, and turns them into a single level-sensitive interrupt for the processor. Every channel signals two events, half-transfer and end-of-transfer. Each event arrives as a one-cycle pulse and sets a sticky pending bit in a 32-bit status word.

A 32-bit enable word with the same bit layout selects which pending bits may drive the interrupt. Software reaches both words through a small register port. Word address 0 selects the enable word and word address 1 selects the status word. Software clears status bits by writing ones to them. The interrupt handler recovers the channel from a status bit index as (index / 2) mod 8, and recovers the group from bit 4 of that index.

Top module: `dma_irq_agg`

## Requirements
- R1: While rst_ni is low, and after it is released, the enable word, the status word, reg_rdata_o and irq_o are all zero.
- R2: A pulse on norm_half_i[c] sets status bit 2c, and a pulse on norm_end_i[c] sets status bit 2c+1. The bit is visible from the clock edge that samples the pulse.
- R3: A pulse on ded_half_i[c] sets status bit 16+2c, and a pulse on ded_end_i[c] sets status bit 17+2c.
- R4: A status bit stays set, regardless of the enable word, until software clears it.
- R5: A write with reg_addr_i=1 clears every status bit whose write-data bit is 1 and leaves every other status bit unchanged. Writing all ones clears the whole word.
- R6: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R7: A write with reg_addr_i=0 loads the full 32-bit enable word, and a write to address 0 leaves the status word unchanged.
- R8: irq_o is high exactly when (status AND enable) is non-zero. It follows the registers in the same cycle they change, and writing 0 to the enable word drops it.
- R9: reg_rdata_o is registered. After each clock edge it holds the word selected by reg_addr_i (0 selects enable, 1 selects status), with the value that word had just before that edge.
- R10: A status bit that was latched while disabled raises irq_o right after the edge that writes its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| norm_half_i | input | 8 | Normal-group half-transfer pulses, one per channel |
| norm_end_i | input | 8 | Normal-group end-of-transfer pulses |
| ded_half_i | input | 8 | Dedicated-group half-transfer pulses |
| ded_end_i | input | 8 | Dedicated-group end-of-transfer pulses |
| reg_addr_i | input | 1 | Word address: 0 selects enable, 1 selects status |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
Event pulses and register writes change the status and enable words at the next rising edge. irq_o is derived from those words without a further register, so it is due on that same edge. Read data lags the address by one edge and shows the word as it stood before any write taken at that edge. The bench drives every input at the falling edge and steps a behavioural model at each rising edge. It compares reg_rdata_o and irq_o at the following falling edge, which keeps each check exactly one edge after its stimulus.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  typedef enum logic {
    REG_EN   = 1'b0,
    REG_STAT = 1'b1
  } reg_sel_e;

  // status bit of channel ch in group grp (0 normal, 1 dedicated)
  function automatic int unsigned stat_bit(int unsigned grp, int unsigned ch,
                                           int unsigned is_end, int unsigned ch_n);
    return grp * 2 * ch_n + 2 * ch + is_end;
  endfunction
endpackage

// File: rtl/dma_irq_event_pack.sv
module dma_irq_event_pack #(
  parameter int unsigned CH_N   = 8,
  localparam int unsigned GRP_N = 2,
  localparam int unsigned STAT_W = 2 * GRP_N * CH_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GRP_N*CH_N-1:0] half_i,
  input  logic [GRP_N*CH_N-1:0] end_i,
  output logic [STAT_W-1:0] ev_o
);
  import dma_irq_pkg::*;

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    for (genvar c = 0; c < CH_N; c++) begin : g_ch
      assign ev_o[stat_bit(g, c, 0, CH_N)] = half_i[g*CH_N+c];
      assign ev_o[stat_bit(g, c, 1, CH_N)] = end_i[g*CH_N+c];
    end
  end

  assert_pack_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ev_o) == $countones({half_i, end_i}));
  // R3: the end pulse of a channel always lands above its half bit
  assert_pack_pair_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((end_i == '0) |-> ((ev_o & {(STAT_W/2){2'b10}}) == '0)));
endmodule

// File: rtl/dma_irq_pending.sv
module dma_irq_pending #(
  parameter int unsigned STAT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] ev_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_mask_i,
  output logic [STAT_W-1:0] pend_o
);
  logic [STAT_W-1:0] pend_d;
  logic              past_ok;

  always_comb begin
    pend_d = pend_o;
    if (clr_we_i) pend_d = pend_d & ~clr_mask_i;
    pend_d = pend_d | ev_i;  // set wins over clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o  <= '0;
      past_ok <= 1'b0;
    end else begin
      pend_o  <= pend_d;
      past_ok <= 1'b1;
    end
  end

  assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(clr_we_i)) |-> ((pend_o & $past(pend_o)) == $past(pend_o)));
  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ((pend_o & $past(ev_i)) == $past(ev_i)));
  assert_w1c_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(clr_we_i)) |-> ((pend_o & $past(clr_mask_i & ~ev_i)) == '0));
endmodule

// File: rtl/dma_irq_enable.sv
module dma_irq_enable #(
  parameter int unsigned STAT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_we_i,
  input  logic [STAT_W-1:0] en_wdata_i,
  output logic [STAT_W-1:0] en_o
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (en_we_i) en_o <= en_wdata_i;
    end
  end

  assert_en_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(en_we_i)) |-> (en_o == $past(en_wdata_i)));
  assert_en_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(en_we_i)) |-> $stable(en_o));
endmodule

// File: rtl/dma_irq_regport.sv
module dma_irq_regport #(
  parameter int unsigned STAT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              we_i,
  input  logic [STAT_W-1:0] en_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              en_we_o,
  output logic              clr_we_o,
  output logic [STAT_W-1:0] rdata_o
);
  import dma_irq_pkg::*;

  reg_sel_e sel;
  assign sel      = reg_sel_e'(addr_i);
  assign en_we_o  = we_i && (sel == REG_EN);
  assign clr_we_o = we_i && (sel == REG_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= (sel == REG_STAT) ? stat_i : en_i;
  end

  assert_we_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({en_we_o, clr_we_o}));
  assert_we_seen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (en_we_o || clr_we_o));
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg #(
  parameter int unsigned CH_N    = 8,
  localparam int unsigned STAT_W = 4 * CH_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CH_N-1:0]   norm_half_i,
  input  logic [CH_N-1:0]   norm_end_i,
  input  logic [CH_N-1:0]   ded_half_i,
  input  logic [CH_N-1:0]   ded_end_i,
  input  logic              reg_addr_i,
  input  logic              reg_we_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  output logic [STAT_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] ev, pend, en;
  logic              en_we, clr_we;

  dma_irq_event_pack #(.CH_N(CH_N)) u_pack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .half_i({ded_half_i, norm_half_i}),
    .end_i ({ded_end_i, norm_end_i}),
    .ev_o  (ev)
  );

  dma_irq_regport #(.STAT_W(STAT_W)) u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (reg_addr_i),
    .we_i    (reg_we_i),
    .en_i    (en),
    .stat_i  (pend),
    .en_we_o (en_we),
    .clr_we_o(clr_we),
    .rdata_o (reg_rdata_o)
  );

  dma_irq_pending #(.STAT_W(STAT_W)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .clr_we_i  (clr_we),
    .clr_mask_i(reg_wdata_i),
    .pend_o    (pend)
  );

  dma_irq_enable #(.STAT_W(STAT_W)) u_en (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_we_i   (en_we),
    .en_wdata_i(reg_wdata_i),
    .en_o      (en)
  );

  assign irq_o = |(pend & en);

  assert_irq_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_o);
  assert_irq_nopend_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |-> !irq_o);
  always_comb begin
    if (!rst_ni) assert_rst_quiet_R1: assert (!irq_o);
  end
endmodule

// File: tb/dma_irq_agg_bench.sv
`timescale 1ns/1ps
module dma_irq_agg_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  nh = '0, ne = '0, dh = '0, de = '0;
  logic        addr = 1'b1, we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  logic [31:0] m_en, m_pend, m_rd;

  always #2 clk_i = ~clk_i;

  dma_irq_agg u_dma_irq_agg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .norm_half_i(nh), .norm_end_i(ne), .ded_half_i(dh), .ded_end_i(de),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wd),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = 0; m_pend = 0; m_rd = 0;
    end else begin
      logic [31:0] evs;
      evs = 0;
      for (int c = 0; c < 8; c++) begin
        evs[2*c]    = nh[c];
        evs[2*c+1]  = ne[c];
        evs[16+2*c] = dh[c];
        evs[17+2*c] = de[c];
      end
      m_rd = addr ? m_pend : m_en;
      if (we && addr) m_pend = (m_pend & ~wd) | evs;
      else            m_pend = m_pend | evs;
      if (we && !addr) m_en = wd;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    check(rdata, m_rd, "rdata");
    check({31'd0, irq}, {31'd0, |(m_pend & m_en)}, "irq");
  endtask

  // drive one cycle of stimulus, then check one edge later
  task automatic step(input logic a, input logic w, input logic [31:0] d,
                      input logic [7:0] h0, input logic [7:0] e0,
                      input logic [7:0] h1, input logic [7:0] e1);
    addr = a; we = w; wd = d; nh = h0; ne = e0; dh = h1; de = e1;
    @(negedge clk_i);
    addr = 1'b1; we = 1'b0; wd = '0; nh = '0; ne = '0; dh = '0; de = '0;
    compare();
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    cur_req = "R1";
    repeat (3) @(negedge clk_i);
    check(rdata, 32'h0, "reset rdata");
    check({31'd0, irq}, 32'h0, "reset irq");
    rst_ni = 1'b1;
    @(negedge clk_i); compare();
    step(1'b0, 1'b0, 0, 0, 0, 0, 0); // R1: enable reads zero
    check(rdata, 32'h0, "enable after reset");

    cur_req = "R2"; // normal half ch3 -> bit 6, normal end ch5 -> bit 11
    step(1'b1, 1'b0, 0, 8'h08, 8'h20, 0, 0);
    step(1'b1, 1'b0, 0, 0, 0, 0, 0);
    check(rdata, 32'h0000_0840, "normal bits");

    cur_req = "R3"; // dedicated half ch0 -> bit 16, dedicated end ch7 -> bit 31
    step(1'b1, 1'b0, 0, 0, 0, 8'h01, 8'h80);
    step(1'b1, 1'b0, 0, 0, 0, 0, 0);
    check(rdata, 32'h8001_0840, "dedicated bits");

    cur_req = "R4"; // sticky with enable zero, no irq
    repeat (5) step(1'b1, 1'b0, 0, 0, 0, 0, 0);
    check(rdata, 32'h8001_0840, "sticky");
    check({31'd0, irq}, 32'h0, "masked irq");

    cur_req = "R10"; // enable bit 6 and bit 31
    step(1'b0, 1'b1, 32'h8000_0040, 0, 0, 0, 0);
    check({31'd0, irq}, 32'h1, "irq after enable");

    cur_req = "R7";
    step(1'b0, 1'b0, 0, 0, 0, 0, 0);
    check(rdata, 32'h8000_0040, "enable readback");
    step(1'b1, 1'b0, 0, 0, 0, 0, 0);
    check(rdata, 32'h8001_0840, "enable write keeps status");

    cur_req = "R5"; // clear bit 6 only
    step(1'b1, 1'b1, 32'h0000_0040, 0, 0, 0, 0);
    check(rdata, 32'h8001_0840, "read before clear");
    step(1'b1, 1'b0, 0, 0, 0, 0, 0);
    check(rdata, 32'h8001_0800, "partial clear");
    check({31'd0, irq}, 32'h1, "irq held by bit31");

    cur_req = "R6"; // clear all while normal end ch2 (bit 5) fires
    step(1'b1, 1'b1, 32'hFFFF_FFFF, 0, 8'h04, 0, 0);
    step(1'b1, 1'b0, 0, 0, 0, 0, 0);
    check(rdata, 32'h0000_0020, "set wins");
    check({31'd0, irq}, 32'h0, "irq after clear all");

    cur_req = "R8";
    step(1'b0, 1'b1, 32'h0000_0020, 0, 0, 0, 0);
    check({31'd0, irq}, 32'h1, "irq on match");
    step(1'b0, 1'b1, 32'h0, 0, 0, 0, 0);
    check({31'd0, irq}, 32'h0, "irq masked by zero enable");

    cur_req = "R9"; // mixed traffic, model compared each cycle
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      r = lfsr & {lfsr[7:0], lfsr[31:8]} & {lfsr[15:0], lfsr[31:16]};
      step(lfsr[3], (i % 4) == 0, lfsr ^ {lfsr[0 +: 16], lfsr[16 +: 16]},
           r[7:0], r[15:8], r[23:16], r[31:24]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule